// File: doc/BRIEF.md
# Coarse-Grain Reconfigurable Datapath Cell

This block is one processing cell of a mesh of coarse-grain reconfigurable units. It moves 18-bit words: bits 15:0 carry data and bits 17:16 carry decision (condition) flags. Nearest-neighbour ports sit on the north, east, south and west sides, with `PORTS_PER_SIDE` (1 or 2) ports on every side. Each port has both an input and an output handshake in hardware. A configuration bit picks which one is live, and that choice holds for the whole time the cell is armed.

The cell has three roles: unused, routing only, and compute plus routing. In compute, it applies one integer operator to two operands taken from configured input ports. It sends the result to a set of output ports, and more than one port means a fork. Routing, which also runs in compute, copies the word from one input port to a set of output ports without changing it. Execution is transport-triggered. The operator fires only when both operands are valid and the previous result has been taken by every port it went to. Each handshake is valid/ready, so free-form pipelines with forks and joins lose no data.

The setup is shifted in serially, one bit per clock, while the cell is idle. A done strobe then arms the handshake logic. Port index n is side*PORTS_PER_SIDE+k, with sides numbered north 0, east 1, south 2, west 3.

Top module: `cgc_cell`

## Requirements
- R1: The data bits of a comparison result (opcodes 8..13) are zero. Bit 16 holds the 1-bit outcome and bit 17 is zero. Non-comparison results have both decision bits zero, and operand decision bits never affect the operator.
- R2: The operator opcodes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 8 equal, 9 not-equal, 10 less-than unsigned, 11 less-than signed, 12 greater-than unsigned and 13 greater-than signed. Arithmetic wraps modulo 2^16. Opcodes 14 and 15 give an all-zero word.
- R3: The shift opcodes are 5 left, 6 logical right and 7 arithmetic right. The amount is the whole 16-bit data of operand B, and any amount of 16 or more gives zero.
- R4: The operator fires only in a cycle where both operand ports are valid and the previous result is fully taken. The operand ports see inReady only in that cycle, and the result is offered on outValid from the next cycle.
- R5: While an offered word is not accepted, its outValid stays high and its outWord stays stable. Further operands are not consumed.
- R6: A result or routed word is offered on every destination port at once. Each port takes it once, and the source is not accepted again until all destination ports have taken it.
- R7: In the routing and compute roles, the word on the route source port is passed to the route destination ports with all 18 bits unchanged.
- R8: In the compute role, the operator and the route path work independently and can both accept in the same cycle.
- R9: A port whose direction bit is 1 is an output. It never raises inReady, and its inValid is ignored. A port whose direction bit is 0 never raises outValid.
- R10: In the unused role (code 0 or 3), or before the cell is armed, no port raises inReady or outValid.
- R11: The configuration is shifted in first bit first and ends with bit 0 holding the first bit sent. From bit 0 up the layout is role[1:0] (1 route, 2 compute), opcode[3:0], operand A port, operand B port, route source port (each log2 of the port count wide), direction mask, result destination mask and route destination mask. Any shift cycle disarms the cell and drops pending words, and a done pulse arms it.
- R12: When the result and a routed word share an output port, only one word is offered there at a time. In a same-cycle conflict the operator goes first, and a pending word is never overwritten.
- R13: During reset all inReady and outValid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgShiftEn | input | 1 | Shift one configuration bit in |
| cfgBit | input | 1 | Serial configuration bit |
| cfgDone | input | 1 | Arms the cell after loading |
| inValid | input | 4*PORTS_PER_SIDE | Per-port inbound valid |
| inWord | input | 72*PORTS_PER_SIDE | Per-port inbound 18-bit words, port n at bits 18n+17:18n |
| inReady | output | 4*PORTS_PER_SIDE | Per-port inbound accept |
| outValid | output | 4*PORTS_PER_SIDE | Per-port outbound valid |
| outWord | output | 72*PORTS_PER_SIDE | Per-port outbound 18-bit words |
| outReady | input | 4*PORTS_PER_SIDE | Per-port outbound accept |

## Verification
The operator is swept over every opcode with random operands and random decision bits. Shift amounts of 15, 16 and 0xFFFF, and B equal to A, are forced into the mix so that the wrap-to-zero shift rule and the equality compares are exercised rather than left to chance. Directed handshake patterns hold back the consumer to separate firing from holding, and deliver a single operand to show that a partial join does not fire. A fork is accepted in staggered order to show that the source stays blocked until the last taker. Sharing one output port between the operator and the route path shows the ordering, and mixing input-only, output-only and unused roles shows that data on the wrong side of a port is ignored.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  localparam int DATA_W = 16;
  localparam int DEC_W  = 2;
  localparam int WORD_W = DATA_W + DEC_W;
  localparam int OP_W   = 4;
  localparam int ROLE_W = 2;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_OFF     = 2'd0,
    ROLE_ROUTE   = 2'd1,
    ROLE_COMPUTE = 2'd2
  } role_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
    OP_XOR = 4'd4,  OP_SHL = 4'd5,  OP_SHR = 4'd6,  OP_SRA = 4'd7,
    OP_EQ  = 4'd8,  OP_NE  = 4'd9,  OP_LTU = 4'd10, OP_LTS = 4'd11,
    OP_GTU = 4'd12, OP_GTS = 4'd13
  } opcode_e;

  typedef struct packed {
    logic fireOp;
    logic fireRt;
  } strobe_t;

  function automatic logic [WORD_W-1:0] aluEval(
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [DATA_W-1:0] d;
    logic cmpRes;
    logic isCmp;
    logic bigShift;
    d        = '0;
    cmpRes   = 1'b0;
    isCmp    = 1'b0;
    bigShift = |b[DATA_W-1:4];
    case (op)
      OP_ADD: d = a + b;
      OP_SUB: d = a - b;
      OP_AND: d = a & b;
      OP_OR:  d = a | b;
      OP_XOR: d = a ^ b;
      OP_SHL: d = bigShift ? '0 : a << b[3:0];
      OP_SHR: d = bigShift ? '0 : a >> b[3:0];
      OP_SRA: d = bigShift ? '0 : DATA_W'($signed(a) >>> b[3:0]);
      OP_EQ:  begin isCmp = 1'b1; cmpRes = (a == b); end
      OP_NE:  begin isCmp = 1'b1; cmpRes = (a != b); end
      OP_LTU: begin isCmp = 1'b1; cmpRes = (a < b); end
      OP_LTS: begin isCmp = 1'b1; cmpRes = ($signed(a) < $signed(b)); end
      OP_GTU: begin isCmp = 1'b1; cmpRes = (a > b); end
      OP_GTS: begin isCmp = 1'b1; cmpRes = ($signed(a) > $signed(b)); end
      default: d = '0;
    endcase
    return isCmp ? {1'b0, cmpRes, {DATA_W{1'b0}}} : {{DEC_W{1'b0}}, d};
  endfunction
endpackage

// File: rtl/cgc_cfg.sv
module cgc_cfg
  import cgc_pkg::*;
#(
  parameter int NP    = 4,
  parameter int IW    = 2,
  parameter int CFG_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgShiftEn,
  input  logic                 cfgBit,
  input  logic                 cfgDone,
  output logic                 armed,
  output logic [ROLE_W-1:0]    role,
  output logic [OP_W-1:0]      opcode,
  output logic [IW-1:0]        srcA,
  output logic [IW-1:0]        srcB,
  output logic [IW-1:0]        rtSrc,
  output logic [NP-1:0]        dirMask,
  output logic [NP-1:0]        opDest,
  output logic [NP-1:0]        rtDest
);
  localparam int OFF_OP  = ROLE_W;
  localparam int OFF_A   = OFF_OP + OP_W;
  localparam int OFF_B   = OFF_A + IW;
  localparam int OFF_R   = OFF_B + IW;
  localparam int OFF_DIR = OFF_R + IW;
  localparam int OFF_OD  = OFF_DIR + NP;
  localparam int OFF_RD  = OFF_OD + NP;

  logic [CFG_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      armed <= 1'b0;
    end else if (cfgShiftEn) begin
      shReg <= {cfgBit, shReg[CFG_W-1:1]};
      armed <= 1'b0;
    end else if (cfgDone) begin
      armed <= 1'b1;
    end
  end

  assign role    = shReg[0 +: ROLE_W];
  assign opcode  = shReg[OFF_OP +: OP_W];
  assign srcA    = shReg[OFF_A +: IW];
  assign srcB    = shReg[OFF_B +: IW];
  assign rtSrc   = shReg[OFF_R +: IW];
  assign dirMask = shReg[OFF_DIR +: NP];
  assign opDest  = shReg[OFF_OD +: NP];
  assign rtDest  = shReg[OFF_RD +: NP];
endmodule

// File: rtl/cgc_ctrl.sv
module cgc_ctrl
  import cgc_pkg::*;
#(
  parameter int NP = 4,
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgShiftEn,
  input  logic              armed,
  input  logic [ROLE_W-1:0] role,
  input  logic [IW-1:0]     srcA,
  input  logic [IW-1:0]     srcB,
  input  logic [IW-1:0]     rtSrc,
  input  logic [NP-1:0]     dirMask,
  input  logic [NP-1:0]     opDest,
  input  logic [NP-1:0]     rtDest,
  input  logic [NP-1:0]     inValid,
  input  logic [NP-1:0]     outReady,
  output logic [NP-1:0]     inReady,
  output logic [NP-1:0]     outValid,
  output logic [NP-1:0]     selOp,
  output strobe_t           stb
);
  logic [NP-1:0] opPend, rtPend;
  logic [NP-1:0] opDestEff, rtDestEff;
  logic isOp, isRt, aValid, bValid, rValid;
  logic fireOp, fireRt;

  always_comb begin
    isOp      = armed && (role == ROLE_COMPUTE);
    isRt      = armed && ((role == ROLE_ROUTE) || (role == ROLE_COMPUTE));
    aValid    = inValid[srcA] && !dirMask[srcA];
    bValid    = inValid[srcB] && !dirMask[srcB];
    rValid    = inValid[rtSrc] && !dirMask[rtSrc];
    opDestEff = opDest & dirMask;
    rtDestEff = rtDest & dirMask;
    fireOp    = isOp && aValid && bValid && (opPend == '0)
                && ((opDestEff & rtPend) == '0);
    fireRt    = isRt && rValid && (rtPend == '0)
                && ((rtDestEff & opPend) == '0)
                && !(fireOp && ((opDestEff & rtDestEff) != '0));
    for (int p = 0; p < NP; p++) begin
      inReady[p] = !dirMask[p] &&
                   ((fireOp && ((IW'(p) == srcA) || (IW'(p) == srcB))) ||
                    (fireRt && (IW'(p) == rtSrc)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opPend <= '0;
      rtPend <= '0;
    end else if (cfgShiftEn) begin
      opPend <= '0;
      rtPend <= '0;
    end else begin
      opPend <= fireOp ? opDestEff : (opPend & ~outReady);
      rtPend <= fireRt ? rtDestEff : (rtPend & ~outReady);
    end
  end

  assign outValid   = opPend | rtPend;
  assign selOp      = opPend;
  assign stb.fireOp = fireOp;
  assign stb.fireRt = fireRt;
endmodule

// File: rtl/cgc_dp.sv
module cgc_dp
  import cgc_pkg::*;
#(
  parameter int NP = 4,
  parameter int IW = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [OP_W-1:0]    opcode,
  input  logic [IW-1:0]      srcA,
  input  logic [IW-1:0]      srcB,
  input  logic [IW-1:0]      rtSrc,
  input  logic [NP-1:0]      selOp,
  input  logic [NP*WORD_W-1:0] inWord,
  output logic [NP*WORD_W-1:0] outWord
);
  logic [DATA_W-1:0] opA, opB;
  logic [WORD_W-1:0] rtIn, opReg, rtReg;

  assign opA  = inWord[srcA*WORD_W +: DATA_W];
  assign opB  = inWord[srcB*WORD_W +: DATA_W];
  assign rtIn = inWord[rtSrc*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
      rtReg <= '0;
    end else begin
      if (stb.fireOp) opReg <= aluEval(opcode, opA, opB);
      if (stb.fireRt) rtReg <= rtIn;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_out
    assign outWord[p*WORD_W +: WORD_W] = selOp[p] ? opReg : rtReg;
  end
endmodule

// File: rtl/cgc_cell.sv
module cgc_cell
  import cgc_pkg::*;
#(
  parameter int PORTS_PER_SIDE = 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cfgShiftEn,
  input  logic                                cfgBit,
  input  logic                                cfgDone,
  input  logic [4*PORTS_PER_SIDE-1:0]         inValid,
  input  logic [4*PORTS_PER_SIDE*WORD_W-1:0]  inWord,
  output logic [4*PORTS_PER_SIDE-1:0]         inReady,
  output logic [4*PORTS_PER_SIDE-1:0]         outValid,
  output logic [4*PORTS_PER_SIDE*WORD_W-1:0]  outWord,
  input  logic [4*PORTS_PER_SIDE-1:0]         outReady
);
  localparam int NP    = 4 * PORTS_PER_SIDE;
  localparam int IW    = $clog2(NP);
  localparam int CFG_W = ROLE_W + OP_W + 3 * IW + 3 * NP;

  logic              armed;
  logic [ROLE_W-1:0] role;
  logic [OP_W-1:0]   opcode;
  logic [IW-1:0]     srcA, srcB, rtSrc;
  logic [NP-1:0]     dirMask, opDest, rtDest, selOp;
  strobe_t           stb;

  cgc_cfg #(.NP(NP), .IW(IW), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .armed(armed), .role(role), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .rtSrc(rtSrc), .dirMask(dirMask),
    .opDest(opDest), .rtDest(rtDest)
  );

  cgc_ctrl #(.NP(NP), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .armed(armed),
    .role(role), .srcA(srcA), .srcB(srcB), .rtSrc(rtSrc),
    .dirMask(dirMask), .opDest(opDest), .rtDest(rtDest),
    .inValid(inValid), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .selOp(selOp), .stb(stb)
  );

  cgc_dp #(.NP(NP), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opcode(opcode), .srcA(srcA),
    .srcB(srcB), .rtSrc(rtSrc), .selOp(selOp), .inWord(inWord),
    .outWord(outWord)
  );
endmodule

// File: rtl/cgc_cell_chk.sv
module cgc_cell_chk #(
  parameter int NP = 4,
  parameter int W  = 18
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgShiftEn,
  input logic [NP-1:0]   inValid,
  input logic [NP-1:0]   inReady,
  input logic [NP-1:0]   outValid,
  input logic [NP-1:0]   outReady,
  input logic [NP*W-1:0] outWord
);
  // R9: a port is never both an accepting input and an offering output
  p_one_dir_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((inReady & outValid) == '0));

  // R4: an accept is only given to a port that presents data
  p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((inReady & ~inValid) == '0));

  // R11: a shift cycle leaves the cell silent
  p_shift_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgShiftEn |=> (outValid == '0 && inReady == '0));

  for (genvar p = 0; p < NP; p++) begin : g_port
    // R5: an offered word stays put until taken
    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[p] && !outReady[p] && !cfgShiftEn)
        |=> (outValid[p] && $stable(outWord[p*W +: W])));
  end
endmodule

bind cgc_cell cgc_cell_chk #(.NP(NP), .W(cgc_pkg::WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .inValid(inValid),
  .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outWord(outWord)
);

// File: tb/cgc_cell_tb.sv
`timescale 1ns/1ps
module cgc_cell_tb;
  localparam int NP = 4;
  localparam int W  = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgShiftEn = 1'b0, cfgBit = 1'b0, cfgDone = 1'b0;
  logic [NP-1:0] inValid = '0, outReady = '0;
  logic [NP*W-1:0] inWord = '0;
  logic [NP-1:0] inReady, outValid;
  logic [NP*W-1:0] outWord;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cgc_cell #(.PORTS_PER_SIDE(1)) u_dut (
    .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outWord(outWord),
    .outReady(outReady)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] refAlu(input int op, input logic [15:0] a,
                                          input logic [15:0] b);
    int sa, sb;
    logic [15:0] d;
    bit c, cmp;
    d = 0; c = 0; cmp = 0;
    sa = a[15] ? int'(a) - 65536 : int'(a);
    sb = b[15] ? int'(b) - 65536 : int'(b);
    case (op)
      0: d = 16'((int'(a) + int'(b)) % 65536);
      1: d = 16'((int'(a) - int'(b) + 65536) % 65536);
      2: d = a & b;
      3: d = a | b;
      4: d = a ^ b;
      5: d = (b >= 16) ? 16'h0 : 16'((int'(a) * (1 << b)) % 65536);
      6: d = (b >= 16) ? 16'h0 : 16'(int'(a) / (1 << b));
      7: d = (b >= 16) ? 16'h0 : ((a >> b) | (a[15] ? ~(16'hFFFF >> b) : 16'h0));
      8:  begin cmp = 1; c = (a == b); end
      9:  begin cmp = 1; c = (a != b); end
      10: begin cmp = 1; c = (a < b); end
      11: begin cmp = 1; c = (sa < sb); end
      12: begin cmp = 1; c = (a > b); end
      13: begin cmp = 1; c = (sa > sb); end
      default: d = 0;
    endcase
    return cmp ? {1'b0, c, 16'h0} : {2'b00, d};
  endfunction

  function automatic string reqOf(input int op);
    if (op >= 5 && op <= 7) return "R3";
    if (op >= 8 && op <= 13) return "R1";
    return "R2";
  endfunction

  // R11: fields from bit 0 up: role, opcode, srcA, srcB, rtSrc, dir, opDest, rtDest
  task automatic loadCfg(input logic [1:0] role, input logic [3:0] op,
                         input logic [1:0] sA, input logic [1:0] sB,
                         input logic [1:0] sR, input logic [3:0] dir,
                         input logic [3:0] od, input logic [3:0] rd);
    logic [23:0] v;
    v = {rd, od, dir, sR, sB, sA, op, role};
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      cfgShiftEn = 1'b1;
      cfgBit = v[i];
    end
    @(negedge clk);
    cfgShiftEn = 1'b0;
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  function automatic logic [17:0] slice(input logic [NP*W-1:0] bus, input int p);
    return bus[p*W +: W];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] a, b;
    logic [17:0] wA, wB, wR, exp;
    void'($urandom(32'd20250611));

    // R13: reset state with inputs asserted
    inValid = 4'hF;
    repeat (3) @(negedge clk);
    #1;
    check(inReady == 0 && outValid == 0, "R13 reset quiet", {inReady, outValid}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(inReady == 0, "R10 unarmed ready", inReady, 0);
    @(negedge clk);
    check(outValid == 0, "R10 unarmed valid", outValid, 0);
    inValid = 0;

    // R1 R2 R3: every opcode, A=N(0), B=E(1), result to S(2); W(3) output
    outReady = 4'b0100;
    for (int op = 0; op < 16; op++) begin
      loadCfg(2'd2, 4'(op), 2'd0, 2'd1, 2'd2, 4'b1100, 4'b0100, 4'b0000);
      for (int it = 0; it < 12; it++) begin
        @(negedge clk);
        a = 16'($urandom);
        case (it)
          0: b = 16'd15;
          1: b = 16'd16;
          2: b = 16'hFFFF;
          3: b = a;
          default: case ($urandom % 3)
            0: b = 16'($urandom % 20);
            1: b = a;
            default: b = 16'($urandom);
          endcase
        endcase
        wA = {2'($urandom), a};
        wB = {2'($urandom), b};
        inWord = {18'h0, 18'h0, wB, wA};
        inValid = 4'b0011;
        #1;
        check(inReady == 4'b0011, "R4 fire accepts both", inReady, 4'b0011);
        @(negedge clk);
        inValid = 0;
        exp = refAlu(op, a, b);
        check(outValid == 4'b0100, "R4 result offered", outValid, 4'b0100);
        check(slice(outWord, 2) == exp, reqOf(op), slice(outWord, 2), exp);
      end
    end
    @(negedge clk);

    // R4 R5: backpressure and single-operand join
    loadCfg(2'd2, 4'd0, 2'd0, 2'd1, 2'd2, 4'b1100, 4'b0100, 4'b0000);
    outReady = 0;
    @(negedge clk);
    inWord = {18'h0, 18'h0, 18'd7, 18'd5};
    inValid = 4'b0001;
    #1;
    check(inReady == 0, "R4 one operand no fire", inReady, 0);
    @(negedge clk);
    check(outValid == 0, "R4 one operand no output", outValid, 0);
    inValid = 4'b0011;
    #1;
    check(inReady == 4'b0011, "R4 join fires", inReady, 4'b0011);
    @(negedge clk);
    inWord = {18'h0, 18'h0, 18'd100, 18'd200};
    #1;
    check(inReady == 0, "R5 busy output blocks", inReady, 0);
    @(negedge clk);
    check(outValid == 4'b0100 && slice(outWord, 2) == 18'd12, "R5 held word",
          slice(outWord, 2), 18'd12);
    outReady = 4'b0100;
    #1;
    check(inReady == 0, "R4 not free in ack cycle", inReady, 0);
    @(negedge clk);
    #1;
    check(inReady == 4'b0011, "R4 fires once free", inReady, 4'b0011);
    @(negedge clk);
    inValid = 0;
    check(slice(outWord, 2) == 18'd300, "R4 second result", slice(outWord, 2), 18'd300);

    // R9: data on output-direction ports is ignored
    @(negedge clk);
    outReady = 0;
    inWord = {18'h3ABCD, 18'h1234, 18'h0, 18'h0};
    inValid = 4'b1100;
    #1;
    check(inReady == 0, "R9 output port no ready", inReady, 0);
    @(negedge clk);
    check(outValid == 0, "R9 output port ignored", outValid, 0);
    inValid = 0;

    // R6 R7: route N to a fork on S and W
    loadCfg(2'd1, 4'd0, 2'd0, 2'd0, 2'd0, 4'b1100, 4'b0000, 4'b1100);
    @(negedge clk);
    wR = 18'h2F00D;
    inWord = {54'h0, wR};
    inValid = 4'b0001;
    #1;
    check(inReady == 4'b0001, "R7 route accepts", inReady, 4'b0001);
    @(negedge clk);
    check(outValid == 4'b1100, "R6 fork offered", outValid, 4'b1100);
    check(slice(outWord, 2) == wR && slice(outWord, 3) == wR, "R7 word unchanged",
          slice(outWord, 3), wR);
    inWord = {54'h0, 18'h1BEEF};
    outReady = 4'b0100;
    #1;
    check(inReady == 0, "R6 source held", inReady, 0);
    @(negedge clk);
    check(outValid == 4'b1000 && slice(outWord, 3) == wR, "R6 one taker left",
          {outValid, 14'h0}, {4'b1000, 14'h0});
    outReady = 4'b1000;
    #1;
    check(inReady == 0, "R6 source held until last", inReady, 0);
    @(negedge clk);
    check(outValid == 0, "R6 each port once", outValid, 0);
    outReady = 0;
    #1;
    check(inReady == 4'b0001, "R6 source freed", inReady, 4'b0001);
    @(negedge clk);
    inValid = 0;
    check(slice(outWord, 2) == 18'h1BEEF, "R7 next word", slice(outWord, 2), 18'h1BEEF);
    outReady = 4'b1100;
    @(negedge clk);

    // R8: operator N+N to S while routing E to W
    loadCfg(2'd2, 4'd0, 2'd0, 2'd0, 2'd1, 4'b1100, 4'b0100, 4'b1000);
    outReady = 0;
    @(negedge clk);
    inWord = {36'h0, 18'h30042, 18'h00123};
    inValid = 4'b0011;
    #1;
    check(inReady == 4'b0011, "R8 both paths accept", inReady, 4'b0011);
    @(negedge clk);
    inValid = 0;
    check(outValid == 4'b1100, "R8 both offered", outValid, 4'b1100);
    check(slice(outWord, 2) == 18'h00246 && slice(outWord, 3) == 18'h30042,
          "R8 words", slice(outWord, 2), 18'h00246);
    outReady = 4'b1100;
    @(negedge clk);

    // R12: operator and route share S
    loadCfg(2'd2, 4'd0, 2'd0, 2'd1, 2'd3, 4'b0100, 4'b0100, 4'b0100);
    outReady = 0;
    @(negedge clk);
    inWord = {18'h25555, 18'h0, 18'd3, 18'd4};
    inValid = 4'b1011;
    #1;
    check(inReady == 4'b0011, "R12 operator first", inReady, 4'b0011);
    @(negedge clk);
    check(slice(outWord, 2) == 18'd7, "R12 operator word", slice(outWord, 2), 18'd7);
    inValid = 4'b1000;
    #1;
    check(inReady == 0, "R12 route waits", inReady, 0);
    outReady = 4'b0100;
    @(negedge clk);
    #1;
    check(inReady == 4'b1000, "R12 route after", inReady, 4'b1000);
    @(negedge clk);
    inValid = 0;
    check(outValid == 4'b0100 && slice(outWord, 2) == 18'h25555, "R12 routed word",
          slice(outWord, 2), 18'h25555);
    @(negedge clk);

    // R10: unused role
    loadCfg(2'd0, 4'd0, 2'd0, 2'd1, 2'd0, 4'b1100, 4'b0100, 4'b1000);
    @(negedge clk);
    inValid = 4'b0011;
    #1;
    check(inReady == 0, "R10 unused no ready", inReady, 0);
    @(negedge clk);
    check(outValid == 0, "R10 unused no valid", outValid, 0);
    inValid = 0;

    // R11: shifting drops a pending word
    loadCfg(2'd2, 4'd0, 2'd0, 2'd1, 2'd2, 4'b1100, 4'b0100, 4'b0000);
    outReady = 0;
    @(negedge clk);
    inWord = {36'h0, 18'd1, 18'd1};
    inValid = 4'b0011;
    @(negedge clk);
    inValid = 0;
    check(outValid == 4'b0100, "R11 pending before shift", outValid, 4'b0100);
    cfgShiftEn = 1'b1;
    cfgBit = 1'b0;
    @(negedge clk);
    cfgShiftEn = 1'b0;
    check(outValid == 0, "R11 shift clears", outValid, 0);
    inValid = 4'b0011;
    #1;
    check(inReady == 0, "R11 disarmed", inReady, 0);
    @(negedge clk);
    inValid = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule